// File: doc/BRIEF.md
# 8-bit ALU with status flags

This block is the arithmetic and logic unit of a small accumulator-oriented 8-bit processor, together with the status byte that the unit keeps. The result datapath is purely combinational. The status byte is held in a register inside the block. On each cycle the decoder presents an operation code, a register value (accumulator or index) and an operand byte, and raises `op_valid`. In the same cycle the block returns the result byte, a write enable for the destination register, and the status byte it is about to commit. At the next rising clock edge that value is loaded into the status register.

The status byte has a fixed layout. From bit 7 down to bit 0 it holds N, V, a spare bit that always reads 1, B, D, I, Z and C. Subtraction treats C as an inverted borrow. Compare and bit test change only the flags. The D flag can be set and cleared, but arithmetic always stays binary. No operation modifies B.

Top module: `alu8_status`

## Requirements
- R1: After reset the status byte is 8'h24: the spare bit 5 is 1, I (bit 2) is 1, and every other bit is 0. Bit 5 reads 1 at all times.
- R2: ADD (code 5'h00) gives result = reg + opnd + C modulo 256 and asserts the write enable. C takes the carry out. V (bit 6) is set on two's-complement overflow. N (bit 7) is result bit 7, and Z (bit 1) is set when the result is zero.
- R3: SUB (code 5'h01) gives result = reg − opnd − (1 − C) modulo 256 and asserts the write enable. C=1 means no borrow occurred. V is set on signed overflow, and N and Z follow the result.
- R4: AND (5'h02), OR (5'h03) and XOR (5'h04) write the bitwise result and update only N and Z.
- R5: BIT (5'h05) sets Z when (reg & opnd) is zero, copies opnd bit 7 into N and opnd bit 6 into V, leaves C unchanged, and does not assert the write enable.
- R6: ASL (5'h06) shifts reg left with a 0 entering bit 0 and bit 7 going to C. LSR (5'h07) shifts right with a 0 entering bit 7 and bit 0 going to C. Both write the result and update N and Z.
- R7: ROL (5'h08) shifts left with the old C entering bit 0 and bit 7 going to C. ROR (5'h09) shifts right with the old C entering bit 7 and bit 0 going to C. Both write the result and update N and Z.
- R8: CMP (5'h0A) sets C when reg ≥ opnd (unsigned), sets Z when they are equal, and takes N from bit 7 of reg − opnd. It leaves V unchanged and never asserts the write enable.
- R9: INC (5'h0B) and DEC (5'h0C) write reg ± 1 with wraparound (8'hFF+1 = 8'h00, 8'h00−1 = 8'hFF) and update only N and Z.
- R10: The flag operations are CLC 5'h10 (C=0), SEC 5'h11 (C=1), CLD 5'h12 (D=0), SED 5'h13 (D=1), CLI 5'h14 (I=0), SEI 5'h15 (I=1) and CLV 5'h16 (V=0). Each changes only its own flag and writes no result. With D=1, ADD still gives the binary sum.
- R11: When `op_valid` is low, or the code is not listed above, the write enable stays low and the status byte does not change.
- R12: `status_next` shows the value the status byte will take. The `status` output takes that value at the rising clock edge of a cycle in which `op_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation code |
| reg_in | input | 8 | Accumulator or index register value |
| opnd | input | 8 | Operand byte |
| result | output | 8 | Result byte (zero when not written) |
| result_we | output | 1 | Destination register write enable |
| status_next | output | 8 | Status byte to be committed this cycle |
| status | output | 8 | Registered status byte |

## Verification
The bench builds the block with its default parameters: an 8-bit datapath and reset status 8'h24. With these values the 8'h7F/8'h80 signed boundary and the 8'hFF/8'h00 carry and wrap points are the actual corners the bench drives. Directed sequences set up the carry, overflow and decimal flags before each dependent operation, for example a subtract with and without borrow-in and a compare run while V is set. A stream of random operations then drives all operation codes against a flag model written from the requirements with integer arithmetic.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;
  typedef enum logic [4:0] {
    OP_ADD = 5'h00, OP_SUB = 5'h01, OP_AND = 5'h02, OP_OR  = 5'h03,
    OP_XOR = 5'h04, OP_BIT = 5'h05, OP_ASL = 5'h06, OP_LSR = 5'h07,
    OP_ROL = 5'h08, OP_ROR = 5'h09, OP_CMP = 5'h0A, OP_INC = 5'h0B,
    OP_DEC = 5'h0C,
    OP_CLC = 5'h10, OP_SEC = 5'h11, OP_CLD = 5'h12, OP_SED = 5'h13,
    OP_CLI = 5'h14, OP_SEI = 5'h15, OP_CLV = 5'h16
  } alu_op_e;

  localparam int STAT_W = 8;
  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_I = 2;
  localparam int FL_D = 3;
  localparam int FL_B = 4;
  localparam int FL_U = 5;
  localparam int FL_V = 6;
  localparam int FL_N = 7;
endpackage

// File: rtl/alu8_arith.sv
`timescale 1ns/1ps
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              c_in,
  output logic [DATA_W-1:0] sum,
  output logic              carry,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  function automatic logic [DATA_W:0] add_full(input logic [DATA_W-1:0] x,
                                               input logic [DATA_W-1:0] y,
                                               input logic ci);
    return {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, ci};
  endfunction

  function automatic logic signed_ovf(input logic [DATA_W-1:0] x,
                                      input logic [DATA_W-1:0] y,
                                      input logic [DATA_W-1:0] s);
    logic [DATA_W-1:0] t;
    t = ~(x ^ y) & (x ^ s);
    return t[MSB];
  endfunction

  logic [DATA_W-1:0] b_eff;
  logic              ci_eff;
  logic [DATA_W:0]   full;

  // subtract and compare reuse the adder with the operand inverted
  always_comb begin
    case (op)
      OP_ADD:  begin b_eff = b;             ci_eff = c_in; end
      OP_SUB:  begin b_eff = ~b;            ci_eff = c_in; end
      OP_CMP:  begin b_eff = ~b;            ci_eff = 1'b1; end
      OP_INC:  begin b_eff = '0;            ci_eff = 1'b1; end
      OP_DEC:  begin b_eff = '1;            ci_eff = 1'b0; end
      default: begin b_eff = b;             ci_eff = 1'b0; end
    endcase
  end

  assign full  = add_full(a, b_eff, ci_eff);
  assign sum   = full[MSB:0];
  assign carry = full[DATA_W];
  assign ovf   = signed_ovf(a, b_eff, full[MSB:0]);
endmodule

// File: rtl/alu8_bitwise.sv
`timescale 1ns/1ps
module alu8_bitwise
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              c_in,
  output logic [DATA_W-1:0] res,
  output logic              shift_out
);
  localparam int MSB = DATA_W - 1;

  function automatic logic [DATA_W:0] shl(input logic [DATA_W-1:0] x, input logic fill);
    return {x, fill};
  endfunction

  function automatic logic [DATA_W:0] shr(input logic [DATA_W-1:0] x, input logic fill);
    return {x[0], fill, x[MSB:1]};
  endfunction

  logic [DATA_W:0] left_v;
  logic [DATA_W:0] right_v;
  logic            fill_bit;

  // rotates feed the old carry in, plain shifts feed zero
  assign fill_bit = (op == OP_ROL || op == OP_ROR) ? c_in : 1'b0;
  assign left_v   = shl(a, fill_bit);
  assign right_v  = shr(a, fill_bit);

  always_comb begin
    res       = '0;
    shift_out = c_in;
    case (op)
      OP_AND, OP_BIT: res = a & b;
      OP_OR:          res = a | b;
      OP_XOR:         res = a ^ b;
      OP_ASL, OP_ROL: begin res = left_v[MSB:0];    shift_out = left_v[DATA_W];  end
      OP_LSR, OP_ROR: begin res = right_v[MSB:0];   shift_out = right_v[DATA_W]; end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu8_flag_merge.sv
`timescale 1ns/1ps
module alu8_flag_merge
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              valid,
  input  alu_op_e           op,
  input  logic [STAT_W-1:0] st_cur,
  input  logic [DATA_W-1:0] ar_sum,
  input  logic              ar_carry,
  input  logic              ar_ovf,
  input  logic [DATA_W-1:0] bw_res,
  input  logic              bw_carry,
  input  logic [1:0]        opnd_top,
  output logic [DATA_W-1:0] result,
  output logic              result_we,
  output logic [STAT_W-1:0] st_next
);
  localparam int MSB = DATA_W - 1;

  always_comb begin
    st_next   = st_cur;
    result    = '0;
    result_we = 1'b0;
    if (valid) begin
      case (op)
        OP_ADD, OP_SUB: begin
          result = ar_sum; result_we = 1'b1;
          st_next[FL_N] = ar_sum[MSB]; st_next[FL_Z] = ~|ar_sum;
          st_next[FL_C] = ar_carry;    st_next[FL_V] = ar_ovf;
        end
        OP_CMP: begin
          st_next[FL_N] = ar_sum[MSB]; st_next[FL_Z] = ~|ar_sum;
          st_next[FL_C] = ar_carry;
        end
        OP_INC, OP_DEC: begin
          result = ar_sum; result_we = 1'b1;
          st_next[FL_N] = ar_sum[MSB]; st_next[FL_Z] = ~|ar_sum;
        end
        OP_AND, OP_OR, OP_XOR: begin
          result = bw_res; result_we = 1'b1;
          st_next[FL_N] = bw_res[MSB]; st_next[FL_Z] = ~|bw_res;
        end
        OP_ASL, OP_LSR, OP_ROL, OP_ROR: begin
          result = bw_res; result_we = 1'b1;
          st_next[FL_N] = bw_res[MSB]; st_next[FL_Z] = ~|bw_res;
          st_next[FL_C] = bw_carry;
        end
        OP_BIT: begin
          st_next[FL_Z] = ~|bw_res;
          st_next[FL_N] = opnd_top[1];
          st_next[FL_V] = opnd_top[0];
        end
        OP_CLC: st_next[FL_C] = 1'b0;
        OP_SEC: st_next[FL_C] = 1'b1;
        OP_CLD: st_next[FL_D] = 1'b0;
        OP_SED: st_next[FL_D] = 1'b1;
        OP_CLI: st_next[FL_I] = 1'b0;
        OP_SEI: st_next[FL_I] = 1'b1;
        OP_CLV: st_next[FL_V] = 1'b0;
        default: ;
      endcase
    end
    st_next[FL_U] = 1'b1;
  end
endmodule

// File: rtl/alu8_status.sv
`timescale 1ns/1ps
module alu8_status
  import alu8_pkg::*;
#(
  parameter int               DATA_W      = 8,
  parameter logic [STAT_W-1:0] RST_STATUS = 8'h24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [4:0]        op_code,
  input  logic [DATA_W-1:0] reg_in,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] result,
  output logic              result_we,
  output logic [STAT_W-1:0] status_next,
  output logic [STAT_W-1:0] status
);
  localparam int MSB = DATA_W - 1;

  alu_op_e           op_e;
  logic [DATA_W-1:0] ar_sum, bw_res;
  logic              ar_carry, ar_ovf, bw_carry;
  logic [STAT_W-1:0] status_q;

  assign op_e = alu_op_e'(op_code);

  alu8_arith #(.DATA_W(DATA_W)) u_arith (
    .op(op_e), .a(reg_in), .b(opnd), .c_in(status_q[FL_C]),
    .sum(ar_sum), .carry(ar_carry), .ovf(ar_ovf)
  );

  alu8_bitwise #(.DATA_W(DATA_W)) u_bitwise (
    .op(op_e), .a(reg_in), .b(opnd), .c_in(status_q[FL_C]),
    .res(bw_res), .shift_out(bw_carry)
  );

  alu8_flag_merge #(.DATA_W(DATA_W)) u_merge (
    .valid(op_valid), .op(op_e), .st_cur(status_q),
    .ar_sum(ar_sum), .ar_carry(ar_carry), .ar_ovf(ar_ovf),
    .bw_res(bw_res), .bw_carry(bw_carry), .opnd_top(opnd[MSB -: 2]),
    .result(result), .result_we(result_we), .st_next(status_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        status_q <= RST_STATUS | (STAT_W'(1) << FL_U);
    else if (op_valid) status_q <= status_next;
  end

  assign status = status_q;

  // status register guards
  a_r1_spare_bit_high: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[FL_U]);
  a_r11_idle_holds_status: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(status_q));
  a_r12_commit_next: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> status_q == $past(status_next));

  // result enable guards
  a_r8_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_e == OP_CMP) |-> !result_we);
  a_r5_bit_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_e == OP_BIT) |-> (!result_we && status_next[FL_C] == status_q[FL_C]));
  a_r11_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !result_we);

  // flag behaviour guards
  a_r8_cmp_keeps_v: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_e == OP_CMP) |-> status_next[FL_V] == status_q[FL_V]);
  a_r9_incdec_keeps_cv: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_e == OP_INC || op_e == OP_DEC)) |->
      (status_next[FL_C] == status_q[FL_C] && status_next[FL_V] == status_q[FL_V]));
  a_r3_sub_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_e == OP_SUB && status_q[FL_C] && reg_in >= opnd) |-> status_next[FL_C]);
  a_r10_clc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_e == OP_CLC) |=> !status_q[FL_C]);
  a_r6_asl_carry_out: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_e == OP_ASL) |-> status_next[FL_C] == reg_in[MSB]);
  a_r2_b_flag_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    status_next[FL_B] == status_q[FL_B]);
endmodule

// File: tb/alu8_status_tb.sv
`timescale 1ns/1ps
module alu8_status_tb;
  localparam real HALF = 10.0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [4:0] op_code = '0;
  logic [7:0] reg_in = '0, opnd = '0;
  logic [7:0] result, status_next, status;
  logic       result_we;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(HALF) clk = ~clk;

  alu8_status u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .reg_in(reg_in), .opnd(opnd), .result(result), .result_we(result_we),
    .status_next(status_next), .status(status)
  );

  typedef struct {
    string      tag;
    logic [7:0] res;
    logic       we;
    logic [7:0] nxt;
    logic [7:0] cur;
  } exp_t;

  exp_t       sb_q[$];
  logic [7:0] model_st;

  // reference model written with integer arithmetic
  function automatic void model(input logic [4:0] op, input logic [7:0] a, b,
                                input logic vld, input logic [7:0] st,
                                output logic [7:0] res, output logic we,
                                output logic [7:0] nx);
    int u, s, sa, sb, c;
    bit nz;
    sa = a; if (a[7]) sa = sa - 256;
    sb = b; if (b[7]) sb = sb - 256;
    c  = st[0];
    nx = st; res = 0; we = 0; nz = 0;
    if (vld) begin
      case (op)
        5'h00: begin u = a + b + c; s = sa + sb + c; res = u[7:0]; we = 1; nz = 1;
                     nx[0] = (u > 255); nx[6] = (s > 127 || s < -128); end
        5'h01: begin u = a - b - (1 - c); s = sa - sb - (1 - c); res = u[7:0]; we = 1; nz = 1;
                     nx[0] = (u >= 0); nx[6] = (s > 127 || s < -128); end
        5'h02: begin res = a & b; we = 1; nz = 1; end
        5'h03: begin res = a | b; we = 1; nz = 1; end
        5'h04: begin res = a ^ b; we = 1; nz = 1; end
        5'h05: begin nx[1] = ((a & b) == 0); nx[7] = b[7]; nx[6] = b[6]; end
        5'h06: begin u = a * 2;       res = u[7:0]; nx[0] = (u > 255); we = 1; nz = 1; end
        5'h07: begin res = a / 2;     nx[0] = a % 2; we = 1; nz = 1; end
        5'h08: begin u = a * 2 + c;   res = u[7:0]; nx[0] = (u > 255); we = 1; nz = 1; end
        5'h09: begin u = a / 2 + 128 * c; res = u[7:0]; nx[0] = a % 2; we = 1; nz = 1; end
        5'h0A: begin u = a - b; nx[0] = (a >= b); nx[1] = (a == b); nx[7] = u[7]; end
        5'h0B: begin u = (a + 1) % 256; res = u[7:0]; we = 1; nz = 1; end
        5'h0C: begin u = (a + 255) % 256; res = u[7:0]; we = 1; nz = 1; end
        5'h10: nx[0] = 0;
        5'h11: nx[0] = 1;
        5'h12: nx[3] = 0;
        5'h13: nx[3] = 1;
        5'h14: nx[2] = 0;
        5'h15: nx[2] = 1;
        5'h16: nx[6] = 0;
        default: ;
      endcase
      if (nz) begin nx[7] = res[7]; nx[1] = (res == 0); end
    end
    nx[5] = 1;
  endfunction

  task automatic drive(input logic [4:0] op, input logic [7:0] a, b,
                       input logic vld, input string tag);
    exp_t e;
    @(negedge clk);
    op_code = op; reg_in = a; opnd = b; op_valid = vld;
    e.tag = tag; e.cur = model_st;
    model(op, a, b, vld, model_st, e.res, e.we, e.nxt);
    sb_q.push_back(e);
    if (vld) model_st = e.nxt;
  endtask

  task automatic check8(input string tag, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected items mid-cycle, after the driver has settled inputs
  always begin
    @(negedge clk);
    #5;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check8(e.tag, "status", status, e.cur);
      check8(e.tag, "result_we", {7'b0, result_we}, {7'b0, e.we});
      if (e.we) check8(e.tag, "result", result, e.res);
      check8(e.tag, "status_next", status_next, e.nxt);
    end
  end

  initial begin
    #(HALF * 2 * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    model_st = 8'h24;
    repeat (3) @(negedge clk);
    check8("R1", "reset status", status, 8'h24);
    rst_n = 1'b1;

    // R2 add: plain, signed overflow, carry out with zero, carry in
    drive(5'h10, 0, 0, 1, "R10_clc");
    drive(5'h00, 8'h42, 8'h10, 1, "R2_add");
    drive(5'h00, 8'h7F, 8'h01, 1, "R2_add_ovf");
    drive(5'h00, 8'hFF, 8'h01, 1, "R2_add_carry_zero");
    drive(5'h00, 8'h10, 8'h20, 1, "R2_add_cin");
    // R10 decimal flag leaves arithmetic binary
    drive(5'h13, 0, 0, 1, "R10_sed");
    drive(5'h10, 0, 0, 1, "R10_clc");
    drive(5'h00, 8'h09, 8'h01, 1, "R10_binary_with_d");
    drive(5'h12, 0, 0, 1, "R10_cld");
    // R3 subtract with and without borrow-in
    drive(5'h11, 0, 0, 1, "R10_sec");
    drive(5'h01, 8'h50, 8'h20, 1, "R3_sub");
    drive(5'h10, 0, 0, 1, "R10_clc");
    drive(5'h01, 8'h50, 8'h20, 1, "R3_sub_borrow_in");
    drive(5'h11, 0, 0, 1, "R10_sec");
    drive(5'h01, 8'h80, 8'h01, 1, "R3_sub_ovf");
    drive(5'h11, 0, 0, 1, "R10_sec");
    drive(5'h01, 8'h00, 8'h01, 1, "R3_sub_borrow_out");
    // R4 logic
    drive(5'h02, 8'hF0, 8'h0F, 1, "R4_and_zero");
    drive(5'h03, 8'h80, 8'h01, 1, "R4_or");
    drive(5'h04, 8'hAA, 8'hAA, 1, "R4_xor");
    // R5 bit test
    drive(5'h05, 8'h0F, 8'hC0, 1, "R5_bit_zero");
    drive(5'h05, 8'hFF, 8'h01, 1, "R5_bit_nonzero");
    // R6 / R7 shifts and rotates with both carry values
    drive(5'h06, 8'h81, 0, 1, "R6_asl");
    drive(5'h07, 8'h01, 0, 1, "R6_lsr");
    drive(5'h11, 0, 0, 1, "R10_sec");
    drive(5'h08, 8'h40, 0, 1, "R7_rol_cin");
    drive(5'h09, 8'h02, 0, 1, "R7_ror_c0");
    drive(5'h11, 0, 0, 1, "R10_sec");
    drive(5'h09, 8'h01, 0, 1, "R7_ror_cin");
    // R8 compare with V set beforehand
    drive(5'h10, 0, 0, 1, "R10_clc");
    drive(5'h00, 8'h7F, 8'h7F, 1, "R2_add_set_v");
    drive(5'h0A, 8'h33, 8'h33, 1, "R8_cmp_eq");
    drive(5'h0A, 8'h40, 8'h10, 1, "R8_cmp_gt");
    drive(5'h0A, 8'h10, 8'h40, 1, "R8_cmp_lt");
    drive(5'h16, 0, 0, 1, "R10_clv");
    // R9 wraparound
    drive(5'h0B, 8'hFF, 0, 1, "R9_inc_wrap");
    drive(5'h0C, 8'h00, 0, 1, "R9_dec_wrap");
    drive(5'h0B, 8'h7F, 0, 1, "R9_inc_neg");
    // R10 interrupt flag
    drive(5'h14, 0, 0, 1, "R10_cli");
    drive(5'h15, 0, 0, 1, "R10_sei");
    // R11 idle cycle and an unlisted code
    drive(5'h00, 8'hFF, 8'hFF, 0, "R11_idle");
    drive(5'h1F, 8'h12, 8'h34, 1, "R11_unlisted");
    drive(5'h0E, 8'h00, 8'h00, 1, "R11_unlisted");
    // R12 random stream, status commit checked item by item
    for (int i = 0; i < 300; i++) begin
      logic [4:0] rop;
      rop = 5'($urandom_range(0, 31));
      drive(rop, 8'($urandom), 8'($urandom), 1'($urandom_range(0, 3) != 0), "R12_random");
    end
    drive(5'h00, 0, 0, 0, "R12_final");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule